// File: doc/BRIEF.md
# Sample-Rate Enable and Filter Synchronisation Controller

This block sets the sample rhythm for an array of reused multiply-accumulate slots. It divides the system clock by 1, 2, 4 or 8, as chosen by a rate select. It produces a one-clock sample strobe and a slot index that walks through the reuse slots of each sample period. Sampling starts only when it is locked to an external filter-enable input, or when a free-run input is set. The filter-enable input must then stay high for as long as data keeps arriving.

An active-low clear request, or a reset, starts a clear sequence. The sequence drives an accumulator-clear strobe for one whole sample period and raises BUSY while it runs. BUSY is also high while an external coefficient load is in progress. After a clear, sampling stays stopped until filter enable is seen high again with BUSY low.

The block has two further side paths. It registers the result-bus high-impedance request. It also sends out a copy of filter enable delayed by one device's data-path latency, which aligns the next device in a cascade.

Top module: `sample_sync_ctrl`

## Requirements
- R1: While running, `sampleEn` is high for exactly one clock in every N clocks, where N = 1, 2, 4, 8 for `rateSel` = 0, 1, 2, 3. `slotIdx` counts 0 up to N-1 and is 0 in the cycle where `sampleEn` is high.
- R2: While waiting, sampling stays off until the first rising clock edge at which `filtEn` is high and `loadBusy` is low. `sampleEn` is high with `slotIdx` = 0 in the cycle that follows that edge.
- R3: With `freeRun` high, sampling starts at the next edge without any `filtEn` high. It continues while `freeRun` stays high, and stops at the first edge where both `freeRun` and `filtEn` are low.
- R4: A low `clrReqN` at a rising edge puts the block into clearing. In the N cycles after that edge, `accClr` and `busy` are high and `sampleEn` is low. After the next edge, both `accClr` and `busy` are low.
- R5: When a clear ends, the block waits. A `filtEn` high seen while `busy` was still high does not start sampling. The first edge with `filtEn` high after `busy` drops restarts sampling with `slotIdx` = 0.
- R6: While running with `freeRun` low, a low `filtEn` at an edge stops sampling. `sampleEn` stays low after that edge until a new start.
- R7: `busHiZ` takes the value of `hiZReq` at the next rising edge and not before. High means the result bus is in high impedance. Its reset value is 1.
- R8: `filtEnDly` equals `filtEn` delayed by D rising edges. D is 16, 16, 20 or 24 for `rateSel` = 0, 1, 2, 3 (parameter defaults).
- R9: While `rstN` is low: `sampleEn` = 0, `filtEnDly` = 0, and `busy` = `accClr` = 1. After release, `busy` stays high for N edges and then drops, with the block waiting.
- R10: `busy` is high in the same cycle that `loadBusy` is high. A load blocks any start. A load that begins while running stops sampling at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 2 | Clock-to-sample ratio select: N = 2^rateSel |
| filtEn | input | 1 | Filter enable; its first sampled high marks the first sample |
| freeRun | input | 1 | Run without waiting for a filter-enable high |
| clrReqN | input | 1 | Active-low one-clock accumulator clear request |
| loadBusy | input | 1 | Coefficient load in progress |
| hiZReq | input | 1 | Result bus high-impedance request |
| sampleEn | output | 1 | One-clock sample strobe (clock enable) |
| slotIdx | output | 3 | Reuse slot within the current sample period |
| accClr | output | 1 | Accumulator clear strobe |
| busy | output | 1 | Reset, clear or load in progress |
| busHiZ | output | 1 | Registered high-impedance control for the result bus |
| filtEnDly | output | 1 | Delayed filter enable for the next cascaded device |

## Verification
The bench builds the block with its default parameters: a four-entry rate table and delay latencies of 16, 16, 20 and 24 clocks. These defaults bring every clock ratio within reach. That covers ratio 1, where the strobe is high on every clock, and ratio 8, where a clear spans eight clocks. Because the 20- and 24-clock latencies differ from the 16-clock ones, a wrong delay tap shows up as an edge at the wrong cycle. The scenarios cover a clear with filter enable held high across it, and a load that starts during running.

// File: rtl/smpl_sync_pkg.sv
package smpl_sync_pkg;

  // Number of selectable clock-to-sample ratios (1, 2, 4, 8)
  localparam int unsigned NUM_RATES = 4;
  localparam int unsigned RATE_W    = $clog2(NUM_RATES);
  localparam int unsigned MAX_DIV   = 1 << (NUM_RATES - 1);
  localparam int unsigned PHASE_W   = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2
  } syncState_e;

  // Strobes from the sequencer to the counting datapath
  typedef struct packed {
    logic phaseRestart;  // realign the sample phase at the next edge
    logic clrRestart;    // restart the clear-length counter
    logic runActive;     // sequencer is in the running state
    logic clrActive;     // sequencer is clearing accumulators
  } ctrlStrobe_t;

endpackage

// File: rtl/smpl_fen_delay.sv
module smpl_fen_delay
  import smpl_sync_pkg::*;
#(
  parameter int unsigned TAPS [NUM_RATES] = '{16, 16, 20, 24},
  parameter int unsigned DEPTH = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] sel,
  input  logic              din,
  output logic              dout
);

  logic [DEPTH-1:0]     shiftReg;
  logic [NUM_RATES-1:0] tapVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[DEPTH-2:0], din};
  end

  // One tap per rate; each tap sits at its own latency
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    assign tapVal[g] = shiftReg[TAPS[g]-1];
  end

  assign dout = tapVal[sel];

endmodule

// File: rtl/smpl_sync_ctrl_fsm.sv
module smpl_sync_ctrl_fsm
  import smpl_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        filtEn,
  input  logic        freeRun,
  input  logic        clrReqN,
  input  logic        loadBusy,
  input  logic        clrLast,
  output ctrlStrobe_t strobe,
  output logic        busy
);

  syncState_e state, stateNxt;
  logic       goReq;

  assign goReq = filtEn || freeRun;

  always_comb begin
    stateNxt            = state;
    strobe.phaseRestart = 1'b0;
    strobe.clrRestart   = 1'b0;
    if (!clrReqN) begin
      stateNxt          = ST_CLEAR;
      strobe.clrRestart = 1'b1;
    end else begin
      unique case (state)
        ST_CLEAR: if (clrLast) stateNxt = ST_WAIT;
        ST_WAIT: begin
          if (goReq && !loadBusy) begin
            stateNxt            = ST_RUN;
            strobe.phaseRestart = 1'b1;
          end
        end
        ST_RUN: if (loadBusy || !goReq) stateNxt = ST_WAIT;
        default: stateNxt = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CLEAR;
    else       state <= stateNxt;
  end

  assign strobe.runActive = (state == ST_RUN);
  assign strobe.clrActive = (state == ST_CLEAR);
  assign busy             = (state == ST_CLEAR) || loadBusy;

  // R2/R3: entering the running state needs an enable and no load
  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_WAIT) |-> ($past(goReq) && !$past(loadBusy)));

  // R4: a clear request is followed by busy
  assert_busy_after_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clrReqN |=> busy);

  // R5: leaving the clear never jumps straight into running
  assert_clear_to_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_CLEAR && state != ST_CLEAR) |-> state == ST_WAIT);

endmodule

// File: rtl/smpl_sync_dp.sv
module smpl_sync_dp
  import smpl_sync_pkg::*;
#(
  parameter int unsigned FEN_LAT [NUM_RATES] = '{16, 16, 20, 24}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATE_W-1:0]  rateSel,
  input  ctrlStrobe_t        strobe,
  input  logic               filtEn,
  input  logic               hiZReq,
  output logic               clrLast,
  output logic               sampleEn,
  output logic [PHASE_W-1:0] slotIdx,
  output logic               accClr,
  output logic               busHiZ,
  output logic               filtEnDly
);

  localparam int unsigned LAT01   = (FEN_LAT[0] > FEN_LAT[1]) ? FEN_LAT[0] : FEN_LAT[1];
  localparam int unsigned LAT23   = (FEN_LAT[2] > FEN_LAT[3]) ? FEN_LAT[2] : FEN_LAT[3];
  localparam int unsigned LAT_MAX = (LAT01 > LAT23) ? LAT01 : LAT23;

  logic [PHASE_W-1:0] divM1;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] clrCnt;

  always_comb divM1 = PHASE_W'((1 << rateSel) - 1);

  // Sample phase within the period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    phase <= '0;
    else if (strobe.phaseRestart) phase <= '0;
    else if (strobe.runActive)    phase <= (phase >= divM1) ? '0 : phase + 1'b1;
  end

  // Clear length counter: one full sample period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  clrCnt <= '0;
    else if (strobe.clrRestart) clrCnt <= '0;
    else if (strobe.clrActive)  clrCnt <= clrCnt + 1'b1;
  end

  assign clrLast  = strobe.clrActive && (clrCnt >= divM1);
  assign sampleEn = strobe.runActive && (phase == '0);
  assign slotIdx  = strobe.runActive ? phase : '0;
  assign accClr   = strobe.clrActive;

  // Registered output enable, high-impedance after reset
  logic oeArmed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busHiZ  <= 1'b1;
      oeArmed <= 1'b0;
    end else begin
      busHiZ  <= hiZReq;
      oeArmed <= 1'b1;
    end
  end

  smpl_fen_delay #(.TAPS(FEN_LAT), .DEPTH(LAT_MAX)) fenDly_i (
    .clk (clk),
    .rstN(rstN),
    .sel (rateSel),
    .din (filtEn),
    .dout(filtEnDly)
  );

  // Gap checker for R1: strobe spacing equals the ratio
  logic [PHASE_W:0]  gapCnt;
  logic              gapValid;
  logic [RATE_W-1:0] selSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      gapValid <= 1'b0;
      selSeen  <= '0;
    end else begin
      selSeen <= rateSel;
      if (!strobe.runActive || rateSel != selSeen) gapValid <= 1'b0;
      else if (sampleEn)                           gapValid <= 1'b1;
      if (sampleEn) gapCnt <= '0;
      else          gapCnt <= gapCnt + 1'b1;
    end
  end

  assert_sample_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && gapValid && rateSel == selSeen) |-> gapCnt == {1'b0, divM1});

  assert_clear_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrActive |-> clrCnt <= divM1);

  assert_oe_registered_R7: assert property (@(posedge clk) disable iff (!rstN)
    oeArmed |-> busHiZ == $past(hiZReq));

endmodule

// File: rtl/sample_sync_ctrl.sv
module sample_sync_ctrl
  import smpl_sync_pkg::*;
#(
  parameter int unsigned FEN_LAT [NUM_RATES] = '{16, 16, 20, 24}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATE_W-1:0]  rateSel,
  input  logic               filtEn,
  input  logic               freeRun,
  input  logic               clrReqN,
  input  logic               loadBusy,
  input  logic               hiZReq,
  output logic               sampleEn,
  output logic [PHASE_W-1:0] slotIdx,
  output logic               accClr,
  output logic               busy,
  output logic               busHiZ,
  output logic               filtEnDly
);

  ctrlStrobe_t strobe;
  logic        clrLast;

  smpl_sync_ctrl_fsm ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .filtEn  (filtEn),
    .freeRun (freeRun),
    .clrReqN (clrReqN),
    .loadBusy(loadBusy),
    .clrLast (clrLast),
    .strobe  (strobe),
    .busy    (busy)
  );

  smpl_sync_dp #(.FEN_LAT(FEN_LAT)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .rateSel  (rateSel),
    .strobe   (strobe),
    .filtEn   (filtEn),
    .hiZReq   (hiZReq),
    .clrLast  (clrLast),
    .sampleEn (sampleEn),
    .slotIdx  (slotIdx),
    .accClr   (accClr),
    .busHiZ   (busHiZ),
    .filtEnDly(filtEnDly)
  );

  // R4: no sample strobe while accumulators are being cleared
  assert_no_sample_in_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> !accClr);

endmodule

// File: tb/sample_sync_ctrl_tb_top.sv
module sample_sync_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] rateSel;
  logic       filtEn, freeRun, clrReqN, loadBusy, hiZReq;
  logic       sampleEn, accClr, busy, busHiZ, filtEnDly;
  logic [2:0] slotIdx;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  sample_sync_ctrl dut_i (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .filtEn(filtEn), .freeRun(freeRun),
    .clrReqN(clrReqN), .loadBusy(loadBusy), .hiZReq(hiZReq), .sampleEn(sampleEn),
    .slotIdx(slotIdx), .accClr(accClr), .busy(busy), .busHiZ(busHiZ), .filtEnDly(filtEnDly)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lat(int sel);
    case (sel)
      0: return 16;
      1: return 16;
      2: return 20;
      default: return 24;
    endcase
  endfunction

  task automatic t_reset();
    rstN = 0; rateSel = 2; filtEn = 0; freeRun = 0; clrReqN = 1; loadBusy = 0; hiZReq = 1;
    #1;
    chk("R9 sampleEn in reset", sampleEn, 0);
    chk("R9 busy in reset", busy, 1);
    chk("R9 accClr in reset", accClr, 1);
    chk("R9 filtEnDly in reset", filtEnDly, 0);
    chk("R7 busHiZ reset value", busHiZ, 1);
    step();
    rstN = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 busy after release", busy, 1);
    end
    step();
    chk("R9 busy drops after N", busy, 0);
    chk("R9 accClr drops", accClr, 0);
    chk("R9 waiting no sample", sampleEn, 0);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R2 no sample without enable", sampleEn, 0);
    end
  endtask

  task automatic t_rate(int sel);
    int n = 1 << sel;
    rateSel = sel[1:0];
    filtEn = 1;
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < n; i++) begin
        step();
        chk((p == 0 && i == 0) ? "R2 first sample" : "R1 sample strobe", sampleEn, (i == 0) ? 1 : 0);
        chk("R1 slot index", slotIdx, i);
      end
    end
    filtEn = 0;
    for (int k = 0; k < 2 * n; k++) begin
      step();
      chk("R6 stopped after enable low", sampleEn, 0);
    end
  endtask

  task automatic t_free();
    rateSel = 1;
    freeRun = 1;
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R3 free run strobe", sampleEn, (k % 2 == 0) ? 1 : 0);
    end
    freeRun = 0;
    step();
    chk("R3 stops when free run drops", sampleEn, 0);
  endtask

  task automatic t_clear(int sel, bit holdEn);
    int n = 1 << sel;
    rateSel = sel[1:0];
    filtEn = 1;
    step(); step(); step();
    clrReqN = 0;
    filtEn = holdEn;
    for (int k = 0; k < n; k++) begin
      step();
      clrReqN = 1;
      chk("R4 busy during clear", busy, 1);
      chk("R4 accClr during clear", accClr, 1);
      chk("R4 no sample during clear", sampleEn, 0);
    end
    step();
    chk("R4 busy after clear", busy, 0);
    chk("R4 accClr after clear", accClr, 0);
    chk("R5 no sample when clear ends", sampleEn, 0);
    if (!holdEn) begin
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R5 waits for new enable", sampleEn, 0);
      end
      filtEn = 1;
    end
    step();
    chk("R5 resync sample", sampleEn, 1);
    chk("R5 resync slot", slotIdx, 0);
    filtEn = 0;
    step();
  endtask

  task automatic t_load();
    rateSel = 0;
    filtEn = 1;
    loadBusy = 1;
    #1;
    chk("R10 busy follows load", busy, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10 load blocks start", sampleEn, 0);
    end
    loadBusy = 0;
    #1;
    chk("R10 busy after load", busy, 0);
    step();
    chk("R10 start after load", sampleEn, 1);
    step();
    chk("R1 ratio one strobe", sampleEn, 1);
    loadBusy = 1;
    step();
    chk("R10 load stops run", sampleEn, 0);
    loadBusy = 0;
    step();
    chk("R10 restart after load", sampleEn, 1);
    filtEn = 0;
    step();
  endtask

  task automatic t_oe();
    hiZReq = 0;
    #1;
    chk("R7 no change before edge", busHiZ, 1);
    step();
    chk("R7 enabled after edge", busHiZ, 0);
    hiZReq = 1;
    #1;
    chk("R7 hold before edge", busHiZ, 0);
    step();
    chk("R7 high-Z after edge", busHiZ, 1);
  endtask

  task automatic t_delay(int sel);
    int d = lat(sel);
    rateSel = sel[1:0];
    filtEn = 0;
    repeat (30) step();
    filtEn = 1;
    for (int i = 1; i < d; i++) step();
    chk("R8 delayed enable not yet", filtEnDly, 0);
    step();
    chk("R8 delayed enable rises", filtEnDly, 1);
    filtEn = 0;
    for (int i = 1; i < d; i++) step();
    chk("R8 delayed enable holds", filtEnDly, 1);
    step();
    chk("R8 delayed enable falls", filtEnDly, 0);
  endtask

  task automatic t_reset_run();
    rateSel = 1;
    filtEn = 1;
    step(); step();
    rstN = 0;
    #1;
    chk("R9 reset while running sample", sampleEn, 0);
    chk("R9 reset while running busy", busy, 1);
    chk("R9 reset clears delay", filtEnDly, 0);
    filtEn = 0;
    step();
    rstN = 1;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    for (int s = 0; s < 4; s++) t_rate(s);
    t_free();
    t_clear(3, 1'b0);
    t_clear(1, 1'b1);
    t_load();
    t_oe();
    t_delay(0);
    t_delay(3);
    t_reset_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule